// File: doc/BRIEF.md
# Watchdog Debug-Mode Unlock Controller

This block is the mode sequencer of a supervisory chip. It decides when the software watchdog may be switched off so that firmware can be debugged. Its inputs are command bytes that a serial front end has already decoded, presented as a one-cycle strobe with a read/write flag. It also takes a power-on event, a wake-up event and a 1 ms tick. Its outputs are the current mode, a reset request, a watchdog enable and the response to a read of the mode register.

After power-on the block sits in a timed request mode. If nothing configures it before the window closes, it issues a reset, waits out the reset, and opens a new window. The watchdog is released only by a fixed, uninterrupted series of three writes: a timing write, an arming write and a debug select. The series must start while the power-up flag is still set and must end inside one window. Any deviation cancels the series. Once in a debug variant, software can move between the normal, standby and stop debug modes, or leave debug. A wake-up from stop debug opens a fresh window in which a debug mode can be re-selected without arming.

Top module: `wdu_unlock_ctrl`

## Requirements
- R1: After reset the mode output is request (code 1), the power-up flag is set, reset_req is 0 and wdog_en is 1.
- R2: In request mode the WIN_MS-th tick since the window opened moves the block to reset mode (code 0). reset_req is then high for RST_CYC cycles, after which the block returns to request mode with a new window, and the loop repeats.
- R3: A write of a timing byte (upper nibble 0110, bit 3 zero) in request mode moves the block to run mode (code 2).
- R4: A read of the mode register (upper nibble 0001, cmd_write 0) gives rd_valid=1 in the following cycle, with rd_flag equal to the power-up flag, and clears the flag.
- R5: Starting with the flag set, the writes timing byte, mode byte 0x10 and a mode byte whose low three bits are 101, issued back to back within one window, enter normal debug (code 3) with wdog_en 0.
- R6: If the flag was read before the timing write, the same three writes leave the block in run mode with wdog_en 1.
- R7: A write that is not the next step of the series (a skipped step or any other byte) cancels the series, and a later select has no effect.
- R8: If the window closes after the timing write but before the select, the series is cancelled without a reset, and a later select has no effect.
- R9: In any debug mode, mode bytes with low bits 101, 110 and 111 select normal debug (3), standby debug (4) and stop debug (5), all with wdog_en 0.
- R10: In any debug mode, mode byte 0x10 returns the block to run mode with wdog_en 1.
- R11: A wake event in stop debug opens a request window. A mode byte with low bits 101 or 110 in that window selects normal or standby debug directly. If the window expires, the block resets. Wake is ignored in other debug modes.
- R12: A power-on event overrides any mode: request mode, flag set, series cleared.
- R13: Outside a wake window, writes other than the timing byte are ignored in request mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, acts as power-on |
| cmd_valid | input | 1 | One-cycle command byte strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_byte | input | 8 | Address nibble [7:4], data nibble [3:0] |
| por_evt | input | 1 | Power-on event pulse |
| wake_evt | input | 1 | Wake-up event pulse |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| mode | output | 3 | Current mode code |
| reset_req | output | 1 | Reset request, high in reset mode |
| wdog_en | output | 1 | Watchdog enable, low only in debug modes |
| rd_valid | output | 1 | Mode register read response valid |
| rd_flag | output | 1 | Power-up flag value returned by the read |

## Verification
The unlock series is driven in its correct order, with a step skipped, with an unrelated write in the middle, after a read of the flag, and with ticks spread so that the window does or does not close mid-series. These runs separate a design that checks order from one that only counts writes, and a design that requires the flag from one that ignores it. Expiry is tried both in plain request mode and in a wake window, which separates the reset path from the silent cancel in run mode. Reset-length counting confirms the retry loop.

// File: rtl/wdu_pkg.sv
package wdu_pkg;

   typedef enum logic [2:0] {
      MD_RESET    = 3'd0,
      MD_REQ      = 3'd1,
      MD_RUN      = 3'd2,
      MD_DBG_RUN  = 3'd3,
      MD_DBG_STBY = 3'd4,
      MD_DBG_STOP = 3'd5
   } mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_TIM  = 2'd1,
      SQ_ARM  = 2'd2
   } seq_e;

   typedef struct packed {
      logic       wr;
      logic       rd;
      logic       is_mcr;
      logic       is_tim1;
      logic [3:0] data;
   } cmd_t;

   localparam logic [3:0] ADDR_MODE = 4'h1;
   localparam logic [3:0] ADDR_TIM  = 4'h6;
   localparam logic [2:0] SEL_DRUN  = 3'b101;
   localparam logic [2:0] SEL_DSTBY = 3'b110;
   localparam logic [2:0] SEL_DSTOP = 3'b111;

   function automatic logic is_debug(input mode_e m);
      return (m == MD_DBG_RUN) || (m == MD_DBG_STBY) || (m == MD_DBG_STOP);
   endfunction

endpackage

// File: rtl/wdu_cmd_decode.sv
module wdu_cmd_decode
   import wdu_pkg::*;
#(
   parameter bit TIM_SUB_STRICT = 1'b1
) (
   input  logic       cmd_valid,
   input  logic       cmd_write,
   input  logic [7:0] cmd_byte,
   output cmd_t       cmd
);

   logic [3:0] addr;
   logic       tim_hit;

   assign addr = cmd_byte[7:4];

   generate
      if (TIM_SUB_STRICT) begin : g_strict
         assign tim_hit = (addr == ADDR_TIM) && !cmd_byte[3];
      end else begin : g_loose
         assign tim_hit = (addr == ADDR_TIM);
      end
   endgenerate

   always_comb begin
      cmd.wr      = cmd_valid && cmd_write;
      cmd.rd      = cmd_valid && !cmd_write;
      cmd.is_mcr  = (addr == ADDR_MODE);
      cmd.is_tim1 = tim_hit;
      cmd.data    = cmd_byte[3:0];
   end

endmodule

// File: rtl/wdu_span_cnt.sv
module wdu_span_cnt #(
   parameter int unsigned LIMIT = 4,
   localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   input  logic step,
   output logic done
);

   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   initial assert (LIMIT >= 2) else $error("wdu_span_cnt: LIMIT must be at least 2");

   assign done = run && step && !restart && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (restart)      cnt_q <= '0;
      else if (run && step)  cnt_q <= done ? '0 : cnt_q + 1'b1;
   end

   // R2: the span counter never passes its last value
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R2: a restart always brings the count back to zero
   assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));

endmodule

// File: rtl/wdu_unlock_ctrl.sv
module wdu_unlock_ctrl
   import wdu_pkg::*;
#(
   parameter int unsigned WIN_MS         = 350,
   parameter int unsigned RST_CYC        = 16,
   parameter bit          TIM_SUB_STRICT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic       cmd_write,
   input  logic [7:0] cmd_byte,
   input  logic       por_evt,
   input  logic       wake_evt,
   input  logic       ms_tick,
   output logic [2:0] mode,
   output logic       reset_req,
   output logic       wdog_en,
   output logic       rd_valid,
   output logic       rd_flag
);

   initial assert (WIN_MS >= 2)  else $error("wdu_unlock_ctrl: WIN_MS must be at least 2");
   initial assert (RST_CYC >= 2) else $error("wdu_unlock_ctrl: RST_CYC must be at least 2");

   cmd_t  c;
   mode_e mode_q, mode_d;
   seq_e  seq_q, seq_d;
   logic  flag_q, flag_d;
   logic  wakewin_q, wakewin_d;
   logic  rdv_q, rdf_q;
   logic  win_restart, rst_restart;
   logic  win_done, rst_done, win_run, rst_run;
   logic  in_dbg;

   wdu_cmd_decode #(.TIM_SUB_STRICT(TIM_SUB_STRICT)) u_dec (
      .cmd_valid (cmd_valid),
      .cmd_write (cmd_write),
      .cmd_byte  (cmd_byte),
      .cmd       (c)
   );

   assign win_run = (mode_q == MD_REQ) || ((mode_q == MD_RUN) && (seq_q != SQ_IDLE));
   assign rst_run = (mode_q == MD_RESET);

   wdu_span_cnt #(.LIMIT(WIN_MS)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (win_restart),
      .run     (win_run),
      .step    (ms_tick),
      .done    (win_done)
   );

   wdu_span_cnt #(.LIMIT(RST_CYC)) u_rst (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (rst_restart),
      .run     (rst_run),
      .step    (1'b1),
      .done    (rst_done)
   );

   always_comb begin
      mode_d      = mode_q;
      seq_d       = seq_q;
      flag_d      = flag_q;
      wakewin_d   = wakewin_q;
      win_restart = 1'b0;
      rst_restart = 1'b0;
      if (c.rd && c.is_mcr) flag_d = 1'b0;
      if (por_evt) begin
         mode_d      = MD_REQ;
         flag_d      = 1'b1;
         seq_d       = SQ_IDLE;
         wakewin_d   = 1'b0;
         win_restart = 1'b1;
      end else begin
         case (mode_q)
            MD_RESET: begin
               if (rst_done) begin
                  mode_d      = MD_REQ;
                  win_restart = 1'b1;
               end
            end
            MD_REQ: begin
               if (win_done) begin
                  mode_d      = MD_RESET;
                  rst_restart = 1'b1;
                  wakewin_d   = 1'b0;
                  seq_d       = SQ_IDLE;
               end else if (c.wr) begin
                  if (wakewin_q) begin
                     if (c.is_mcr && c.data[2:0] == SEL_DRUN) begin
                        mode_d    = MD_DBG_RUN;
                        wakewin_d = 1'b0;
                     end else if (c.is_mcr && c.data[2:0] == SEL_DSTBY) begin
                        mode_d    = MD_DBG_STBY;
                        wakewin_d = 1'b0;
                     end else if (c.is_tim1) begin
                        mode_d    = MD_RUN;
                        wakewin_d = 1'b0;
                     end
                  end else if (c.is_tim1) begin
                     mode_d = MD_RUN;
                     seq_d  = flag_q ? SQ_TIM : SQ_IDLE;
                  end
               end
            end
            MD_RUN: begin
               if (seq_q != SQ_IDLE) begin
                  if (win_done) begin
                     seq_d = SQ_IDLE;
                  end else if (c.wr) begin
                     if (seq_q == SQ_TIM && c.is_mcr && c.data == 4'b0000 && flag_q) begin
                        seq_d = SQ_ARM;
                     end else if (seq_q == SQ_ARM && c.is_mcr && c.data[2:0] == SEL_DRUN) begin
                        mode_d = MD_DBG_RUN;
                        seq_d  = SQ_IDLE;
                     end else begin
                        seq_d = SQ_IDLE;
                     end
                  end
               end
            end
            MD_DBG_RUN, MD_DBG_STBY, MD_DBG_STOP: begin
               if (mode_q == MD_DBG_STOP && wake_evt) begin
                  mode_d      = MD_REQ;
                  wakewin_d   = 1'b1;
                  win_restart = 1'b1;
               end else if (c.wr && c.is_mcr) begin
                  if (c.data == 4'b0000)               mode_d = MD_RUN;
                  else if (c.data[2:0] == SEL_DRUN)    mode_d = MD_DBG_RUN;
                  else if (c.data[2:0] == SEL_DSTBY)   mode_d = MD_DBG_STBY;
                  else if (c.data[2:0] == SEL_DSTOP)   mode_d = MD_DBG_STOP;
               end
            end
            default: begin
               mode_d      = MD_REQ;
               win_restart = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MD_REQ;
         seq_q     <= SQ_IDLE;
         flag_q    <= 1'b1;
         wakewin_q <= 1'b0;
         rdv_q     <= 1'b0;
         rdf_q     <= 1'b0;
      end else begin
         mode_q    <= mode_d;
         seq_q     <= seq_d;
         flag_q    <= flag_d;
         wakewin_q <= wakewin_d;
         rdv_q     <= c.rd && c.is_mcr;
         rdf_q     <= flag_q;
      end
   end

   assign in_dbg    = is_debug(mode_q);
   assign mode      = mode_q;
   assign reset_req = (mode_q == MD_RESET);
   assign wdog_en   = !in_dbg;
   assign rd_valid  = rdv_q;
   assign rd_flag   = rdf_q;

   // R12: a power-on event always lands in request mode with the flag set
   assert_por_enters_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      por_evt |=> (mode_q == MD_REQ) && flag_q);

   // R2: window expiry in request mode leads to reset mode
   assert_expiry_resets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_REQ && win_done && !por_evt) |=> (mode_q == MD_RESET));

   // R2: the end of the reset span reopens the request window
   assert_reset_returns_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_RESET && rst_done && !por_evt) |=> (mode_q == MD_REQ));

   // R5: debug is entered only right after a mode register write
   assert_dbg_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_dbg) |-> $past(cmd_valid && cmd_write && c.is_mcr));

   // R4: a mode register read clears the flag and answers next cycle
   assert_read_clears_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (c.rd && c.is_mcr && !por_evt) |=> (!flag_q && rd_valid));

   // R10: the exit byte in debug turns the watchdog back on
   assert_exit_enables_wdog_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_dbg && c.wr && c.is_mcr && c.data == 4'b0000 && !por_evt &&
       !(mode_q == MD_DBG_STOP && wake_evt)) |=> wdog_en);

endmodule

// File: tb/wdu_unlock_ctrl_tb.sv
`timescale 1ns/1ps
module wdu_unlock_ctrl_tb_top;

   localparam int WIN = 5;
   localparam int RSTC = 4;

   localparam logic [2:0] OP_IDLE = 3'd0;
   localparam logic [2:0] OP_WR   = 3'd1;
   localparam logic [2:0] OP_RD   = 3'd2;
   localparam logic [2:0] OP_TICK = 3'd3;
   localparam logic [2:0] OP_POR  = 3'd4;
   localparam logic [2:0] OP_WAKE = 3'd5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_write = 1'b0;
   logic [7:0] cmd_byte = 8'h00;
   logic       por_evt = 1'b0;
   logic       wake_evt = 1'b0;
   logic       ms_tick = 1'b0;
   logic [2:0] mode;
   logic       reset_req, wdog_en, rd_valid, rd_flag;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   wdu_unlock_ctrl #(.WIN_MS(WIN), .RST_CYC(RSTC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_byte(cmd_byte), .por_evt(por_evt), .wake_evt(wake_evt), .ms_tick(ms_tick),
      .mode(mode), .reset_req(reset_req), .wdog_en(wdog_en),
      .rd_valid(rd_valid), .rd_flag(rd_flag)
   );

   // fields: req[3:0] op[2:0] byte[7:0] mode[2:0] wdog rdv rdf
   localparam int NV = 26;
   localparam logic [20:0] VEC [NV] = '{
      {4'd13, OP_WR,   8'h15, 3'd1, 1'b1, 2'b00}, // R13 select ignored in request
      {4'd3,  OP_WR,   8'h60, 3'd2, 1'b1, 2'b00}, // R3 timing write
      {4'd5,  OP_WR,   8'h10, 3'd2, 1'b1, 2'b00}, // R5 arm
      {4'd5,  OP_WR,   8'h15, 3'd3, 1'b0, 2'b00}, // R5 select normal debug
      {4'd9,  OP_WR,   8'h16, 3'd4, 1'b0, 2'b00}, // R9 standby debug
      {4'd9,  OP_WR,   8'h1D, 3'd3, 1'b0, 2'b00}, // R9 x101 with bit3 set
      {4'd9,  OP_WR,   8'h17, 3'd5, 1'b0, 2'b00}, // R9 stop debug
      {4'd11, OP_WAKE, 8'h00, 3'd1, 1'b1, 2'b00}, // R11 wake window
      {4'd11, OP_WR,   8'h1E, 3'd4, 1'b0, 2'b00}, // R11 direct standby debug
      {4'd10, OP_WR,   8'h10, 3'd2, 1'b1, 2'b00}, // R10 exit debug
      {4'd7,  OP_WR,   8'h15, 3'd2, 1'b1, 2'b00}, // R7 no series active
      {4'd12, OP_POR,  8'h00, 3'd1, 1'b1, 2'b00}, // R12
      {4'd3,  OP_WR,   8'h60, 3'd2, 1'b1, 2'b00}, // R3
      {4'd7,  OP_WR,   8'h15, 3'd2, 1'b1, 2'b00}, // R7 skipped arm
      {4'd7,  OP_WR,   8'h10, 3'd2, 1'b1, 2'b00}, // R7
      {4'd7,  OP_WR,   8'h15, 3'd2, 1'b1, 2'b00}, // R7
      {4'd12, OP_POR,  8'h00, 3'd1, 1'b1, 2'b00}, // R12
      {4'd3,  OP_WR,   8'h60, 3'd2, 1'b1, 2'b00}, // R3
      {4'd7,  OP_WR,   8'h30, 3'd2, 1'b1, 2'b00}, // R7 foreign write
      {4'd7,  OP_WR,   8'h10, 3'd2, 1'b1, 2'b00}, // R7
      {4'd7,  OP_WR,   8'h15, 3'd2, 1'b1, 2'b00}, // R7
      {4'd12, OP_POR,  8'h00, 3'd1, 1'b1, 2'b00}, // R12
      {4'd4,  OP_RD,   8'h10, 3'd1, 1'b1, 2'b11}, // R4 read returns flag
      {4'd6,  OP_WR,   8'h60, 3'd2, 1'b1, 2'b00}, // R6
      {4'd6,  OP_WR,   8'h10, 3'd2, 1'b1, 2'b00}, // R6
      {4'd6,  OP_WR,   8'h15, 3'd2, 1'b1, 2'b00}  // R6 no debug after read
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] op, input logic [7:0] b);
      @(negedge clk);
      cmd_byte  = b;
      cmd_valid = (op == OP_WR) || (op == OP_RD);
      cmd_write = (op == OP_WR);
      ms_tick   = (op == OP_TICK);
      por_evt   = (op == OP_POR);
      wake_evt  = (op == OP_WAKE);
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_write = 1'b0;
      ms_tick   = 1'b0;
      por_evt   = 1'b0;
      wake_evt  = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) drive(OP_TICK, 8'h00);
   endtask

   task automatic wait_reset_end(input string req);
      int n = 0;
      while (reset_req && n < 50) begin
         n++;
         @(negedge clk);
      end
      chk(req, n, RSTC);
      chk(req, int'(mode), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 mode", int'(mode), 1);
      chk("R1 reset_req", int'(reset_req), 0);
      chk("R1 wdog_en", int'(wdog_en), 1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [20:0] v;
         string tag;
         v = VEC[i];
         drive(v[16:14], v[13:6]);
         tag = $sformatf("R%0d row %0d", v[20:17], i);
         chk({tag, " mode"}, int'(mode), int'(v[5:3]));
         chk({tag, " wdog_en"}, int'(wdog_en), int'(v[2]));
         chk({tag, " rd_valid"}, int'(rd_valid), int'(v[1]));
         if (v[1]) chk({tag, " rd_flag"}, int'(rd_flag), int'(v[0]));
      end

      // R4 second read sees the cleared flag; response lasts one cycle
      drive(OP_RD, 8'h10);
      chk("R4 second read flag", int'(rd_flag), 0);
      drive(OP_IDLE, 8'h00);
      chk("R4 rd_valid one cycle", int'(rd_valid), 0);

      // R2 expiry and retry loop
      drive(OP_POR, 8'h00);
      ticks(WIN - 1);
      chk("R2 before expiry", int'(mode), 1);
      ticks(1);
      chk("R2 expiry mode", int'(mode), 0);
      chk("R2 reset_req", int'(reset_req), 1);
      wait_reset_end("R2 reset length");
      ticks(WIN);
      chk("R2 retry expiry", int'(mode), 0);
      // R12 power-on overrides reset mode
      drive(OP_POR, 8'h00);
      chk("R12 por in reset", int'(mode), 1);
      chk("R12 reset_req", int'(reset_req), 0);

      // R5 with ticks spread inside the window
      drive(OP_POR, 8'h00);
      ticks(2);
      drive(OP_WR, 8'h60);
      ticks(1);
      drive(OP_WR, 8'h10);
      ticks(1);
      drive(OP_WR, 8'h15);
      chk("R5 spread series", int'(mode), 3);
      chk("R5 wdog off", int'(wdog_en), 0);
      // R11 wake ignored outside stop debug
      drive(OP_WAKE, 8'h00);
      chk("R11 wake ignored", int'(mode), 3);

      // R8 window closes mid-series
      drive(OP_POR, 8'h00);
      drive(OP_WR, 8'h60);
      drive(OP_WR, 8'h10);
      ticks(WIN);
      chk("R8 no reset", int'(mode), 2);
      drive(OP_WR, 8'h15);
      chk("R8 late select", int'(mode), 2);
      chk("R8 wdog on", int'(wdog_en), 1);

      // R11 wake window expiry
      drive(OP_POR, 8'h00);
      drive(OP_WR, 8'h60);
      drive(OP_WR, 8'h10);
      drive(OP_WR, 8'h15);
      drive(OP_WR, 8'h17);
      chk("R11 stop debug", int'(mode), 5);
      drive(OP_WAKE, 8'h00);
      ticks(WIN);
      chk("R11 wake expiry", int'(mode), 0);
      wait_reset_end("R11 reset length");

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule